// File: doc/BRIEF.md
# Pin Edge Event and Wakeup Detector

This block watches a bank of already-synchronized pin inputs and reports edge events on them. Every clock it compares each pin with the sample taken one cycle earlier. A transition from low to high counts as a rising edge, and a transition from high to low counts as a falling edge. Each pin has its own enable for each edge direction in the interrupt path. An enabled edge sets a sticky event bit. All event bits together drive one interrupt line for the whole bank. Software acknowledges an event by writing a one to its bit.

A second set of per-pin, per-direction enables feeds a wakeup request. This request is only meaningful while the system is asleep. It ignores the interrupt enables entirely. A per-pin sleep-control bit must be 0 for that pin to take part in wakeup. All configuration and acknowledgement goes through a small bus with single-cycle writes and combinational reads.

Top module: `edgewake_ctrl`

## Requirements
- R1: After reset, every configuration register and every event bit reads 0, and `irq_o` and `wake_o` are low. Reset is asserted asynchronously and released synchronously.
- R2: When a pin goes from 0 to 1 and its bit in the rising interrupt enable (address 0) is 1, its event bit (bit n of address 5 for pin n) is 1 in the cycle after the clock edge that samples the new level.
- R3: When a pin goes from 1 to 0 and its bit in the falling interrupt enable (address 1) is 1, its event bit is set in the same way.
- R4: A pin with both interrupt enables set records both edge directions. An edge whose direction is not enabled for that pin leaves the event bits unchanged. There is no level-triggered behaviour.
- R5: An event bit stays set until software writes 1 to that bit position at address 5. Writing 0 to a bit leaves it unchanged.
- R6: When an enabled edge and a clearing write hit the same bit in the same cycle, the bit ends up set. Other bits cleared by the same write end up clear.
- R7: `irq_o` is high exactly when at least one event bit is set.
- R8: `wake_o` is high only while `sleep_i` is high. It is driven by the rising wake enable (address 2) and the falling wake enable (address 3), and does not depend on the interrupt enables. It is combinational: it is high from the moment a pin takes its new level until the next clock edge.
- R9: A pin can raise `wake_o` only when its bit in the sleep-control register (address 4) is 0.
- R10: Addresses 0 to 4 read back the last value written to them, and address 5 reads the event bits. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| sleep_i | input | 1 | System is in sleep; enables the wakeup output |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt for the bank |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach is the one where a new edge and its acknowledgement land in the same clock. The bench reaches it by changing a pin level and presenting the clearing write on the same falling edge. That write clears one older bit alongside the new one, so both outcomes show up in a single readback. The short combinational window of `wake_o` is caught by sampling 1 ns after the pin changes, and again one cycle later once the stored previous sample has caught up. Each pin is swept through all four combinations of rising and falling interrupt enables in both edge directions.

// File: rtl/edgewake_pkg.sv
`timescale 1ns/1ps
package edgewake_pkg;
  localparam int ADDR_W = 3;
  localparam int NCFG   = 5;   // configuration registers at addresses 0..NCFG-1

  typedef enum logic [ADDR_W-1:0] {
    REG_RISE_IRQ  = 3'd0,
    REG_FALL_IRQ  = 3'd1,
    REG_RISE_WAKE = 3'd2,
    REG_FALL_WAKE = 3'd3,
    REG_SLEEP_CTL = 3'd4,
    REG_EVENTS    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/edgewake_sense.sv
`timescale 1ns/1ps
module edgewake_sense #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  always_comb begin
    prev_d = pin_i;
    rise_o = pin_i & ~prev_q;
    fall_o = ~pin_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  // R4: a pin never reports both directions in one cycle
  assert_one_direction_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & fall_o) == '0);
endmodule

// File: rtl/edgewake_regs.sv
`timescale 1ns/1ps
module edgewake_regs
  import edgewake_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] events_i,
  output logic [NPINS-1:0] rise_irq_o,
  output logic [NPINS-1:0] fall_irq_o,
  output logic [NPINS-1:0] rise_wake_o,
  output logic [NPINS-1:0] fall_wake_o,
  output logic [NPINS-1:0] sleep_ctl_o,
  output logic [NPINS-1:0] clr_o,
  output logic [NPINS-1:0] rdata_o
);
  logic [NCFG-1:0][NPINS-1:0] cfg_q;
  logic [NCFG-1:0]            cfg_en;

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    assign cfg_en[k] = wr_i && (addr_i == ADDR_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cfg_q[k] <= '0;
      else if (cfg_en[k]) cfg_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rise_irq_o  = cfg_q[REG_RISE_IRQ];
    fall_irq_o  = cfg_q[REG_FALL_IRQ];
    rise_wake_o = cfg_q[REG_RISE_WAKE];
    fall_wake_o = cfg_q[REG_FALL_WAKE];
    sleep_ctl_o = cfg_q[REG_SLEEP_CTL];
    clr_o       = (wr_i && addr_i == REG_EVENTS) ? wdata_i : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (addr_i == ADDR_W'(k)) rdata_o = cfg_q[k];
    end
    if (addr_i == REG_EVENTS) rdata_o = events_i;
  end

  // R10: a written enable register holds the written value afterwards
  assert_readback_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_RISE_IRQ) |=> rise_irq_o == $past(wdata_i));
endmodule

// File: rtl/edgewake_status.sv
`timescale 1ns/1ps
module edgewake_status #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] events_o
);
  logic [NPINS-1:0] ev_q;
  logic [NPINS-1:0] ev_d;
  logic [NPINS-1:0] ev_en;

  always_comb begin
    ev_en = set_i | clr_i;
    ev_d  = set_i | (ev_q & ~clr_i);   // set has priority over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
    end else begin
      for (int b = 0; b < NPINS; b++) begin
        if (ev_en[b]) ev_q[b] <= ev_d[b];
      end
    end
  end

  assign events_o = ev_q;

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((ev_q & $past(set_i)) == $past(set_i)));

  assert_clear_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((ev_q & $past(clr_i & ~set_i)) == '0));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
endmodule

// File: rtl/edgewake_ctrl.sv
`timescale 1ns/1ps
module edgewake_ctrl
  import edgewake_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              sleep_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [NPINS-1:0] rise, fall;
  logic [NPINS-1:0] rise_irq, fall_irq, rise_wake, fall_wake, sleep_ctl;
  logic [NPINS-1:0] clr_vec, set_vec, wake_hit, events;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  edgewake_sense #(.NPINS(NPINS)) sense_i (
    .clk_i (clk_i), .rst_ni (rst_int_n), .pin_i (pin_i),
    .rise_o (rise), .fall_o (fall)
  );

  edgewake_regs #(.NPINS(NPINS)) regs_i (
    .clk_i (clk_i), .rst_ni (rst_int_n),
    .wr_i (bus_wr_i), .addr_i (bus_addr_i), .wdata_i (bus_wdata_i),
    .events_i (events),
    .rise_irq_o (rise_irq), .fall_irq_o (fall_irq),
    .rise_wake_o (rise_wake), .fall_wake_o (fall_wake),
    .sleep_ctl_o (sleep_ctl), .clr_o (clr_vec), .rdata_o (bus_rdata_o)
  );

  always_comb begin
    set_vec  = (rise & rise_irq) | (fall & fall_irq);
    wake_hit = ((rise & rise_wake) | (fall & fall_wake)) & ~sleep_ctl;
  end

  edgewake_status #(.NPINS(NPINS)) status_i (
    .clk_i (clk_i), .rst_ni (rst_int_n),
    .set_i (set_vec), .clr_i (clr_vec), .events_o (events)
  );

  assign irq_o  = |events;
  assign wake_o = sleep_i & (|wake_hit);

  assert_wake_needs_sleep_R8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wake_o |-> sleep_i);

  assert_wake_needs_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wake_o |-> ((rise | fall) != '0));

  assert_sleep_ctl_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (&sleep_ctl) |-> !wake_o);

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(irq_o) |-> ($past(set_vec) != '0));
endmodule

// File: tb/edgewake_ctrl_tb_top.sv
`timescale 1ns/1ps
module edgewake_ctrl_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          sleep = 1'b0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic          irq, wake;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  edgewake_ctrl #(.NPINS(NP)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .pin_i (pins), .sleep_i (sleep),
    .bus_wr_i (wr), .bus_addr_i (addr), .bus_wdata_i (wdata),
    .bus_rdata_o (rdata), .irq_o (irq), .wake_o (wake)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [NP-1:0] d);
    @(negedge clk); wr = 1'b0; addr = a; #1 d = rdata;
  endtask

  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk); pins = v;
    @(negedge clk);
  endtask

  task automatic expect_events(input string req, input logic [NP-1:0] exp);
    logic [NP-1:0] v;
    rd_reg(3'd5, v);
    check(req, v, exp);
    check({req, " irq"}, NP'(irq), NP'(exp != '0));
  endtask

  task automatic wake_edge(input logic [NP-1:0] v, input logic exp, input string req);
    @(negedge clk); pins = v;
    #1 check(req, NP'(wake), NP'(exp));
    @(negedge clk);
    check({req, " after edge"}, NP'(wake), '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [NP-1:0] v;
    logic [NP-1:0] acc;
    logic [NP-1:0] pa;
    logic [NP-1:0] pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), v);
      check("R1 reset read", v, '0);
    end
    check("R1 irq", NP'(irq), '0);
    check("R1 wake", NP'(wake), '0);

    // R10: readback and unused addresses
    for (int a = 0; a < 5; a++) wr_reg(3'(a), 32'h1357_9BDF ^ (32'h1111_1111 * a));
    wr_reg(3'd6, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'hFFFF_FFFF);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      check("R10 readback", v, 32'h1357_9BDF ^ (32'h1111_1111 * a));
    end
    rd_reg(3'd6, v); check("R10 addr6", v, '0);
    rd_reg(3'd7, v); check("R10 addr7", v, '0);
    for (int a = 0; a < 5; a++) wr_reg(3'(a), '0);

    // R2 R3 R4 R7: per pin, all four enable combinations, both directions
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 4; m++) begin
        wr_reg(3'd0, m[0] ? (NP'(1) << i) : '0);
        wr_reg(3'd1, m[1] ? (NP'(1) << i) : '0);
        drive(NP'(1) << i);
        expect_events(m[0] ? "R2 rise" : "R4 rise unmasked", m[0] ? (NP'(1) << i) : '0);
        wr_reg(3'd5, NP'(1) << i);
        expect_events("R5 clear", '0);
        drive('0);
        expect_events(m[1] ? "R3 fall" : "R4 fall unmasked", m[1] ? (NP'(1) << i) : '0);
        wr_reg(3'd5, NP'(1) << i);
        check("R8 no wake awake", NP'(wake), '0);
      end
    end

    // R4: many pins, both directions at once
    wr_reg(3'd0, '1); wr_reg(3'd1, '1);
    pa = 32'hA5A5_5A5A; pb = 32'h0F0F_F0F0;
    drive(pa);
    expect_events("R4 multi rise", pa);
    drive(pb);
    acc = pa | (pa ^ pb);
    expect_events("R4 multi both", acc);
    wr_reg(3'd5, '1);
    wr_reg(3'd1, '0);
    drive('0);
    expect_events("R4 fall disabled", '0);

    // R5: sticky, write zero ignored, partial clear
    drive(32'h0000_00FF);
    expect_events("R5 set", 32'h0000_00FF);
    wr_reg(3'd5, '0);
    expect_events("R5 write zero", 32'h0000_00FF);
    repeat (5) @(negedge clk);
    expect_events("R5 held", 32'h0000_00FF);
    wr_reg(3'd5, 32'h0000_000F);
    expect_events("R5 partial", 32'h0000_00F0);
    wr_reg(3'd5, 32'h0000_00F0);
    expect_events("R7 all clear", '0);
    drive('0);

    // R6: set and clear in the same cycle
    drive(32'h1);
    expect_events("R6 prep", 32'h1);
    @(negedge clk);
    pins = 32'h11; wr = 1'b1; addr = 3'd5; wdata = 32'h11;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    expect_events("R6 set wins", 32'h10);
    wr_reg(3'd5, '1);
    drive('0);
    expect_events("R6 cleanup", '0);

    // R8: wake only through wake enables, only while sleeping
    wr_reg(3'd0, '0);
    wr_reg(3'd2, '1);
    sleep = 1'b1;
    for (int i = 0; i < NP; i++) begin
      wake_edge(NP'(1) << i, 1'b1, "R8 rise wake");
      wake_edge('0, 1'b0, "R8 fall not enabled");
    end
    expect_events("R8 no events from wake", '0);
    wr_reg(3'd2, '0); wr_reg(3'd3, '1);
    wake_edge(32'h8000_0000, 1'b0, "R8 rise not enabled");
    wake_edge('0, 1'b1, "R8 fall wake");
    sleep = 1'b0;
    wake_edge(32'h4, 1'b0, "R8 awake rise");
    wake_edge('0, 1'b0, "R8 awake fall");
    sleep = 1'b1;
    wr_reg(3'd3, '0); wr_reg(3'd0, '1); wr_reg(3'd1, '1);
    wake_edge(32'h2, 1'b0, "R8 irq enables only");
    wake_edge('0, 1'b0, "R8 irq enables only fall");
    wr_reg(3'd5, '1);
    wr_reg(3'd0, '0); wr_reg(3'd1, '0);

    // R9: sleep-control gating
    wr_reg(3'd2, '1);
    wr_reg(3'd4, ~(NP'(1) << 5));
    wake_edge(NP'(1) << 5, 1'b1, "R9 enabled pin");
    wake_edge('0, 1'b0, "R9 fall");
    wake_edge(NP'(1) << 6, 1'b0, "R9 blocked pin");
    wake_edge('0, 1'b0, "R9 fall blocked");
    wr_reg(3'd4, '1);
    wake_edge(NP'(1) << 5, 1'b0, "R9 all blocked");
    drive('0);

    finish_run();
  end
endmodule